// File: doc/BRIEF.md
# Single-Stream DMA Transfer Sequencer

This block runs one direct-memory-access stream. Software first loads an item count, a peripheral address, two memory base addresses and a control word. The control word selects the direction, the item size, the two increment enables and the repeat mode. Software then sets the enable bit. For each transfer request the sequencer moves one item over a simple request/acknowledge bus. It first issues a read at the source address, then a write of the captured word at the destination address. After each item it counts down and advances the addresses.

Three repeat modes exist: one-shot, looping and ping-pong. Looping reloads the count and the base addresses when the count runs out. Ping-pong also flips a current-target bit, which swaps the two memory bases at each buffer boundary. When software clears enable while an item is on the bus, that item still finishes before the stream stops. Single-cycle pulses report half-way, completion and bus errors.

Top module: `dma_stream_seq`

## Requirements
- R1: Register selects are 0 control, 1 item count, 2 peripheral address, 3 memory base 0 and 4 memory base 1. While `en_o` is 1, writes to selects 1 to 4 are ignored. A control write that keeps bit 0 at 1 is also ignored while `en_o` is 1.
- R2: A control write with bit 0 at 0 made while no item is on the bus drops `en_o` one cycle later. If an item is on the bus, `en_o` stays 1 and the item's read and write both complete; `en_o` falls after the write acknowledge.
- R3: The direction is in control bits 2:1. Code 0 moves peripheral to memory. Code 1 moves memory to peripheral. Code 2 moves memory to memory: it reads at the peripheral-address pointer, writes at the memory pointer, and needs no `xfer_req_i`. Code 3 behaves like code 0. The written word equals the word returned by the read.
- R4: Writing select 1 loads the count (low 16 bits) and the reload length. `count_o` drops by one at each write acknowledge. A control write that sets bit 0 while the count is 0 is ignored.
- R5: `ht_o` pulses for one cycle after the write acknowledge that leaves floor(length/2) items remaining. `tc_o` pulses for one cycle after the write acknowledge that leaves 0 items remaining.
- R6: The mode is in control bits 8:7: 0 one-shot, 1 looping, 2 ping-pong, 3 one-shot. In one-shot mode the last item clears `en_o` and leaves `count_o` at 0. Looping and ping-pong reload the count and the pointers and keep running. Memory-to-memory always runs as one-shot.
- R7: Control bit 9 is the starting target: 0 selects memory base 0 and 1 selects base 1. In ping-pong mode `ct_o` flips at each buffer completion and the memory pointer restarts at the newly selected base.
- R8: The size code is in control bits 6:5. Code 0 steps the address by 1, code 1 by 2, and codes 2 and 3 by 4. Peripheral increment (bit 3) and memory increment (bit 4) act independently; a pointer that does not increment stays fixed.
- R9: An error response on either bus phase pulses `te_o` for one cycle, clears `en_o` and ends bus requests in the next cycle.
- R10: Out of reset, and again after zeros are written to all five selects while disabled, `en_o`, `count_o`, `ct_o`, `bus_req_o` and the event pulses are all 0.
- R11: Each request moves exactly one item: one read cycle sequence (`bus_we_o` low) followed by one write (`bus_we_o` high). `bus_req_o` is only asserted while `en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | DW | Configuration write data |
| xfer_req_i | input | 1 | Transfer request from the peripheral (level) |
| en_o | output | 1 | Enable bit read-back |
| count_o | output | CW | Items remaining |
| ct_o | output | 1 | Current memory target |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| bus_ack_i | input | 1 | Bus acknowledge |
| bus_err_i | input | 1 | Bus error response |
| ht_o | output | 1 | Half-transfer pulse |
| tc_o | output | 1 | Transfer-complete pulse |
| te_o | output | 1 | Transfer-error pulse |

## Verification
A wrong pointer or a target bit flipped at the wrong time appears on `bus_addr_o` during the next read or write phase, at most three cycles after the item that corrupted it. A wrong count shows on `count_o` in the cycle after the write acknowledge. It then moves the half-way or completion pulse, and in one-shot mode it also changes when `en_o` falls. A stop sequence that loses the item in flight shows up as a missing write phase, or as `en_o` falling while `bus_req_o` is still high without an acknowledge.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {DIR_P2M = 2'd0, DIR_M2P = 2'd1, DIR_M2M = 2'd2, DIR_ALT = 2'd3} dir_e;
  typedef enum logic [1:0] {MODE_ONCE = 2'd0, MODE_LOOP = 2'd1, MODE_PING = 2'd2, MODE_ALT = 2'd3} mode_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} st_e;

  // control word bits 9:1, msb first
  typedef struct packed {
    logic       ct;
    mode_e      mode;
    logic [1:0] size;
    logic       minc;
    logic       pinc;
    dir_e       dir;
  } ctrl_t;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_COUNT = 3'd1;
  localparam logic [2:0] SEL_PADDR = 3'd2;
  localparam logic [2:0] SEL_MB0   = 3'd3;
  localparam logic [2:0] SEL_MB1   = 3'd4;
endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [8:0]    ctrl_bits_i,
  input  logic [AW-1:0] addr_bits_i,
  input  logic          lock_i,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] paddr_o,
  output logic [AW-1:0] mb0_o,
  output logic [AW-1:0] mb1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      paddr_o <= '0;
      mb0_o   <= '0;
      mb1_o   <= '0;
    end else if (we_i && !lock_i) begin
      case (sel_i)
        SEL_CTRL:  ctrl_o  <= ctrl_t'(ctrl_bits_i);
        SEL_PADDR: paddr_o <= addr_bits_i;
        SEL_MB0:   mb0_o   <= addr_bits_i;
        SEL_MB1:   mb1_o   <= addr_bits_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          reload_i,
  output logic [CW-1:0] count_o,
  output logic          last_o,
  output logic          ht_o,
  output logic          tc_o
);
  logic [CW-1:0] len_q;
  logic [CW-1:0] dec;

  assign dec    = count_o - 1'b1;
  assign last_o = (count_o == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      len_q   <= '0;
      ht_o    <= 1'b0;
      tc_o    <= 1'b0;
    end else begin
      ht_o <= step_i && (dec == (len_q >> 1));
      tc_o <= step_i && last_o;
      if (load_i) begin
        count_o <= load_val_i;
        len_q   <= load_val_i;
      end else if (step_i) begin
        count_o <= last_o ? (reload_i ? len_q : '0) : dec;
      end
    end
  end
endmodule

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          wrap_i,
  input  logic          dbuf_i,
  input  logic          pinc_i,
  input  logic          minc_i,
  input  logic [1:0]    size_i,
  input  logic          ct_init_i,
  input  logic [AW-1:0] pbase_i,
  input  logic [AW-1:0] mb0_i,
  input  logic [AW-1:0] mb1_i,
  output logic [AW-1:0] paddr_o,
  output logic [AW-1:0] maddr_o,
  output logic          ct_o
);
  logic [AW-1:0] stp;
  logic          ct_nx;

  always_comb begin
    case (size_i)
      2'd0:    stp = AW'(1);
      2'd1:    stp = AW'(2);
      default: stp = AW'(4);
    endcase
  end

  assign ct_nx = dbuf_i ? ~ct_o : ct_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_o <= '0;
      maddr_o <= '0;
      ct_o    <= 1'b0;
    end else if (load_i) begin
      paddr_o <= pbase_i;
      ct_o    <= ct_init_i;
      maddr_o <= ct_init_i ? mb1_i : mb0_i;
    end else if (step_i && wrap_i) begin
      paddr_o <= pbase_i;
      ct_o    <= ct_nx;
      maddr_o <= ct_nx ? mb1_i : mb0_i;
    end else if (step_i) begin
      if (pinc_i) paddr_o <= paddr_o + stp;
      if (minc_i) maddr_o <= maddr_o + stp;
    end
  end
endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          xfer_req_i,
  output logic          en_o,
  output logic [CW-1:0] count_o,
  output logic          ct_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          bus_err_i,
  output logic          ht_o,
  output logic          tc_o,
  output logic          te_o
);
  ctrl_t         ctrl;
  logic [AW-1:0] pbase, mb0, mb1, paddr, maddr, src, dst;
  st_e           st_q;
  logic          en_q, live_q, stop_q, te_q;
  logic [DW-1:0] data_q;
  logic          wr_ctrl, en_clr, en_set, last, m2m, reload, dbuf, item_done, fault;

  assign wr_ctrl   = cfg_we_i && (cfg_sel_i == SEL_CTRL);
  assign en_clr    = wr_ctrl && !cfg_wdata_i[0] && en_q;
  assign en_set    = wr_ctrl && cfg_wdata_i[0] && !en_q && (count_o != '0);
  assign m2m       = (ctrl.dir == DIR_M2M);
  assign reload    = !m2m && ((ctrl.mode == MODE_LOOP) || (ctrl.mode == MODE_PING));
  assign dbuf      = !m2m && (ctrl.mode == MODE_PING);
  assign fault     = (st_q != ST_IDLE) && bus_err_i;
  assign item_done = (st_q == ST_WR) && bus_ack_i && !bus_err_i;

  assign src = (ctrl.dir == DIR_M2P) ? maddr : paddr;
  assign dst = (ctrl.dir == DIR_M2P) ? paddr : maddr;

  assign en_o        = en_q;
  assign te_o        = te_q;
  assign bus_req_o   = (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = (st_q == ST_WR) ? dst : src;
  assign bus_wdata_o = data_q;

  dma_seq_cfg #(.AW(AW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .sel_i       (cfg_sel_i),
    .ctrl_bits_i (cfg_wdata_i[9:1]),
    .addr_bits_i (cfg_wdata_i[AW-1:0]),
    .lock_i      (en_q),
    .ctrl_o      (ctrl),
    .paddr_o     (pbase),
    .mb0_o       (mb0),
    .mb1_o       (mb1)
  );

  dma_seq_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_we_i && (cfg_sel_i == SEL_COUNT) && !en_q),
    .load_val_i (cfg_wdata_i[CW-1:0]),
    .step_i     (item_done),
    .reload_i   (reload),
    .count_o    (count_o),
    .last_o     (last),
    .ht_o       (ht_o),
    .tc_o       (tc_o)
  );

  dma_seq_ptr #(.AW(AW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (!live_q),
    .step_i    (item_done),
    .wrap_i    (last && reload),
    .dbuf_i    (dbuf),
    .pinc_i    (ctrl.pinc),
    .minc_i    (ctrl.minc),
    .size_i    (ctrl.size),
    .ct_init_i (ctrl.ct),
    .pbase_i   (pbase),
    .mb0_i     (mb0),
    .mb1_i     (mb1),
    .paddr_o   (paddr),
    .maddr_o   (maddr),
    .ct_o      (ct_o)
  );

  // live_q lags en_q so pointers latch the final control word before the first item
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      live_q <= 1'b0;
      stop_q <= 1'b0;
      te_q   <= 1'b0;
      data_q <= '0;
    end else begin
      live_q <= en_q;
      te_q   <= fault;
      if (en_clr && (st_q != ST_IDLE)) stop_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (en_clr) en_q <= 1'b0;
          else if (en_set) en_q <= 1'b1;
          else if (en_q && live_q && (m2m || xfer_req_i)) st_q <= ST_RD;
        end
        ST_RD: begin
          if (bus_err_i) begin
            en_q   <= 1'b0;
            stop_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (bus_ack_i) begin
            data_q <= bus_rdata_i;
            st_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (bus_err_i) begin
            en_q   <= 1'b0;
            stop_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (bus_ack_i) begin
            st_q <= ST_IDLE;
            if (stop_q || en_clr || (last && !reload)) begin
              en_q   <= 1'b0;
              stop_q <= 1'b0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_stream_seq_chk.sv
module dma_stream_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_o,
  input logic [CW-1:0] count_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_ack_i,
  input logic          bus_err_i,
  input logic          tc_o
);
  a_r2_stop_after_item: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o) |-> $past(!bus_req_o || bus_ack_i || bus_err_i));

  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_ack_i && !bus_err_i && (count_o > CW'(1)))
      |=> (count_o == $past(count_o) - 1'b1));

  a_r5_tc_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(bus_req_o && bus_we_o && bus_ack_i));

  a_r9_error_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_err_i) |=> (!en_o && !bus_req_o));

  a_r11_req_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> en_o);

  a_r11_write_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_we_o) |-> $past(bus_req_o && !bus_we_o && bus_ack_i && !bus_err_i));
endmodule

bind dma_stream_seq dma_stream_seq_chk #(.CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_o      (en_o),
  .count_o   (count_o),
  .bus_req_o (bus_req_o),
  .bus_we_o  (bus_we_o),
  .bus_ack_i (bus_ack_i),
  .bus_err_i (bus_err_i),
  .tc_o      (tc_o)
);

// File: tb/dma_stream_seq_test.sv
module dma_stream_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic        req = 1'b0;
  logic        ack_en = 1'b1;
  logic        err_en = 1'b0;
  logic        en, ct, bus_req, bus_we, ht, tc, te, bus_ack, bus_err;
  logic [15:0] count;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  int n_tests = 0, n_fail = 0;
  int ht_seen = 0, tc_seen = 0, te_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign bus_ack   = bus_req & ack_en & ~err_en;
  assign bus_err   = bus_req & err_en;
  assign bus_rdata = bus_addr ^ 32'hA5A5_0000;

  dma_stream_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .xfer_req_i(req), .en_o(en), .count_o(count),
    .ct_o(ct), .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack),
    .bus_err_i(bus_err), .ht_o(ht), .tc_o(tc), .te_o(te)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model state
  int m_en, m_live, m_stop, m_ph, m_cnt, m_len;
  int m_dir, m_pinc, m_minc, m_size, m_mode, m_ctinit, m_ct;
  logic [31:0] m_par, m_m0, m_m1, m_p, m_m, m_data;
  int m_ht, m_tc, m_te;
  int ackv, errv, m2m, rel, dbl, stp, clr, setv, itm, oen, olive, ocnt;

  function automatic logic [31:0] m_src();
    return (m_dir == 1) ? m_m : m_p;
  endfunction
  function automatic logic [31:0] m_dst();
    return (m_dir == 1) ? m_p : m_m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_live = 0; m_stop = 0; m_ph = 0; m_cnt = 0; m_len = 0;
      m_dir = 0; m_pinc = 0; m_minc = 0; m_size = 0; m_mode = 0; m_ctinit = 0; m_ct = 0;
      m_par = 0; m_m0 = 0; m_m1 = 0; m_p = 0; m_m = 0; m_data = 0;
      m_ht = 0; m_tc = 0; m_te = 0;
    end else begin
      ackv  = (m_ph != 0 && ack_en && !err_en) ? 1 : 0;
      errv  = (m_ph != 0 && err_en) ? 1 : 0;
      m2m   = (m_dir == 2) ? 1 : 0;
      rel   = (!m2m && (m_mode == 1 || m_mode == 2)) ? 1 : 0;
      dbl   = (!m2m && m_mode == 2) ? 1 : 0;
      stp   = (m_size >= 2) ? 4 : (1 << m_size);
      clr   = (cfg_we && cfg_sel == 0 && !cfg_wdata[0] && m_en) ? 1 : 0;
      setv  = (cfg_we && cfg_sel == 0 && cfg_wdata[0] && !m_en && m_cnt != 0) ? 1 : 0;
      itm   = (m_ph == 2 && ackv) ? 1 : 0;
      oen   = m_en; olive = m_live; ocnt = m_cnt;
      m_live = oen;
      m_ht = (itm && (ocnt - 1) == (m_len >> 1)) ? 1 : 0;
      m_tc = (itm && ocnt == 1) ? 1 : 0;
      m_te = errv;
      if (!olive) begin
        m_p = m_par; m_ct = m_ctinit; m_m = m_ctinit ? m_m1 : m_m0;
      end else if (itm && ocnt == 1 && rel) begin
        m_p = m_par;
        if (dbl) m_ct = !m_ct;
        m_m = m_ct ? m_m1 : m_m0;
      end else if (itm) begin
        if (m_pinc) m_p = m_p + stp;
        if (m_minc) m_m = m_m + stp;
      end
      if (cfg_we && cfg_sel == 1 && !oen) begin
        m_cnt = cfg_wdata[15:0]; m_len = cfg_wdata[15:0];
      end else if (itm) begin
        m_cnt = (ocnt == 1) ? (rel ? m_len : 0) : ocnt - 1;
      end
      if (cfg_we && !oen) begin
        case (cfg_sel)
          3'd0: begin
            m_dir = cfg_wdata[2:1]; m_pinc = cfg_wdata[3]; m_minc = cfg_wdata[4];
            m_size = cfg_wdata[6:5]; m_mode = cfg_wdata[8:7]; m_ctinit = cfg_wdata[9];
            if (m_dir == 3) m_dir = 0;
            if (m_mode == 3) m_mode = 0;
          end
          3'd2: m_par = cfg_wdata;
          3'd3: m_m0 = cfg_wdata;
          3'd4: m_m1 = cfg_wdata;
          default: ;
        endcase
      end
      case (m_ph)
        0: begin
          if (clr) m_en = 0;
          else if (setv) m_en = 1;
          else if (oen && olive && (m2m || req)) m_ph = 1;
        end
        1: begin
          if (clr) m_stop = 1;
          if (errv) begin m_en = 0; m_stop = 0; m_ph = 0; end
          else if (ackv) begin m_data = m_src() ^ 32'hA5A5_0000; m_ph = 2; end
        end
        default: begin
          if (clr) m_stop = 1;
          if (errv) begin m_en = 0; m_stop = 0; m_ph = 0; end
          else if (ackv) begin
            m_ph = 0;
            if (m_stop || clr || (ocnt == 1 && !rel)) begin m_en = 0; m_stop = 0; end
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 en_o", en, m_en);
      chk("R4 count_o", count, m_cnt);
      chk("R7 ct_o", ct, m_ct);
      chk("R11 bus_req_o", bus_req, (m_ph != 0));
      if (m_ph != 0) begin
        chk("R11 bus_we_o", bus_we, (m_ph == 2));
        chk("R8 bus_addr_o", bus_addr, (m_ph == 1) ? m_src() : m_dst());
      end
      if (m_ph == 2) chk("R3 bus_wdata_o", bus_wdata, m_data);
      chk("R5 ht_o", ht, m_ht);
      chk("R5 tc_o", tc, m_tc);
      chk("R9 te_o", te, m_te);
    end
  end

  always @(posedge clk) begin
    if (ht) ht_seen++;
    if (tc) tc_seen++;
    if (te) te_seen++;
  end

  function automatic logic [31:0] ctl(bit e, int dir, bit pi, bit mi, int sz, int md, bit c);
    return 32'(e) | (32'(dir) << 1) | (32'(pi) << 3) | (32'(mi) << 4) |
           (32'(sz) << 5) | (32'(md) << 7) | (32'(c) << 9);
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int n, input logic [31:0] c);
    wr(3'd2, 32'h4000_0100);
    wr(3'd3, 32'h2000_0000);
    wr(3'd4, 32'h2000_1000);
    wr(3'd1, 32'(n));
    wr(3'd0, c);
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset en_o", en, 0);
    chk("R10 reset count_o", count, 0);
    chk("R10 reset bus_req_o", bus_req, 0);
    chk("R10 reset ct_o", ct, 0);

    // one-shot peripheral to memory, word size, memory increments only
    t0 = tc_seen;
    setup(4, ctl(1, 0, 0, 1, 2, 0, 0));
    req = 1'b1;
    repeat (20) @(negedge clk);
    req = 1'b0;
    chk("R6 one-shot ends en_o", en, 0);
    chk("R6 one-shot count_o", count, 0);
    chk("R5 one tc pulse", tc_seen - t0, 1);

    // ping-pong from base 1, half-word size
    t0 = tc_seen;
    setup(2, ctl(1, 0, 1, 1, 1, 2, 1));
    req = 1'b1;
    repeat (18) @(negedge clk);
    req = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 ping-pong buffers completed", (tc_seen - t0) >= 2, 1);
    chk("R6 ping-pong keeps running", en, 1);
    wr(3'd0, ctl(0, 0, 1, 1, 1, 2, 1));
    chk("R2 idle disable", en, 0);

    // looping memory to peripheral, stop while an item is stalled
    setup(3, ctl(1, 1, 1, 1, 0, 1, 0));
    ack_en = 1'b0;
    req = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd0, ctl(0, 1, 1, 1, 0, 1, 0));
    chk("R2 en held in flight", en, 1);
    repeat (3) @(negedge clk);
    chk("R2 en held while stalled", en, 1);
    chk("R2 item still requested", bus_req, 1);
    ack_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 stopped after item", en, 0);
    chk("R2 one item moved", count, 2);
    req = 1'b0;

    // memory to memory with looping requested: runs once, no request needed
    t0 = tc_seen;
    setup(5, ctl(1, 2, 1, 1, 2, 1, 0));
    repeat (25) @(negedge clk);
    chk("R6 m2m forced one-shot", en, 0);
    chk("R3 m2m ran all items", count, 0);
    chk("R3 m2m completion", tc_seen - t0, 1);

    // writes ignored while enabled
    setup(6, ctl(1, 0, 1, 0, 0, 0, 0));
    ack_en = 1'b0;
    req = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd1, 32'd9);
    wr(3'd2, 32'h0000_1234);
    wr(3'd0, ctl(1, 1, 0, 0, 2, 1, 1));
    chk("R1 count locked", count, 6);
    chk("R1 control locked", en, 1);
    ack_en = 1'b1;
    repeat (25) @(negedge clk);
    req = 1'b0;
    chk("R1 run unchanged to end", en, 0);
    chk("R1 run length kept", count, 0);

    // bus error mid-transfer
    t0 = te_seen;
    setup(4, ctl(1, 0, 0, 1, 2, 0, 0));
    req = 1'b1;
    repeat (6) @(negedge clk);
    err_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 error clears en_o", en, 0);
    chk("R9 error pulse", te_seen - t0, 1);
    chk("R9 bus idle after error", bus_req, 0);
    err_en = 1'b0;
    req = 1'b0;

    // enable refused with zero count
    wr(3'd1, 32'd0);
    wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R4 zero count enable ignored", en, 0);

    // zero writes restore reset state
    wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 1));
    repeat (2) @(negedge clk);
    chk("R7 idle target follows control", ct, 1);
    for (int s = 0; s < 5; s++) wr(3'(s), 32'd0);
    repeat (2) @(negedge clk);
    chk("R10 zeroed en_o", en, 0);
    chk("R10 zeroed count_o", count, 0);
    chk("R10 zeroed ct_o", ct, 0);
    chk("R10 zeroed bus_req_o", bus_req, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule